// File: doc/BRIEF.md
# PCIe Configuration Address/Data Bridge

This block sits behind a host register window and turns processor accesses into configuration-space requests for a downstream PCIe hierarchy. Software first programs a 64-bit target register holding an enable flag, a bus number, a device/function number and a register offset. It then touches a 4-byte data window. Each data-window access becomes one configuration request for the selected function, carrying a dword-aligned offset, a byte lane and a size.

The register region is big-endian, but configuration data is little-endian. Data is therefore byte-swapped according to the access size, in both directions. An access is dropped without any request in three cases: the enable flag is clear, no device answers at the selected bus/function, or the computed offset lies beyond that device's configuration-space size. A dropped write does nothing, and a dropped read returns all ones. The enumeration logic outside the block answers presence and configuration-space size for the function shown on the lookup outputs. Only one read may be outstanding at a time.

Top module: `cfg_window_bridge`

## Requirements
- R1: After reset the target register reads zero, and no request, read-valid or error pulse is present.
- R2: An 8-byte access at the target-register offset with the low three offset bits zero writes the full 64-bit target register. A read of it returns the value with `acc_rvalid` high for one cycle, exactly one cycle after the read is sampled.
- R3: At any offset other than the data window, an access whose size is not 8 or whose offset is not 8-aligned is refused: a write changes nothing and a read returns all ones.
- R4: Bit 63 of the target register is the enable flag. While it is clear, data-window writes issue no request and data-window reads return all ones.
- R5: A request carries bus = target bits 59:52, devfn = target bits 51:44, dword offset = target bits 43:34 followed by two zero bits, and byte lane = bits 1:0 of the access offset. The request goes out one cycle after the access is sampled.
- R6: If the offset {target bits 43:34, lane} is greater than or equal to `dev_cfg_size`, a write has no effect and a read returns all ones. The size is 256 for a conventional device and 4096 for an express device.
- R7: If `dev_present` is low for the function shown on the lookup outputs, a data-window access is dropped in the same way as in R6.
- R8: Write data: a 1-byte access passes byte 0 unchanged. A 2-byte access swaps bytes 0 and 1. A 4-byte access reverses all four bytes. The upper request data bytes are zero for the smaller sizes.
- R9: Read data returned from the device is swapped by the same size rule and zero-extended to 64 bits.
- R10: An access whose offset, with bits 1:0 cleared, equals the window offset is a data-window access. Sizes 1, 2 and 4 are legal there. Any other size pulses `acc_err` for one cycle, issues no request, and a read also returns all ones.
- R11: A forwarded read completes with a single-cycle `acc_rvalid`, one cycle after the cycle in which `cfg_rvalid` is seen, and not before.
- R12: A legal 8-byte aligned read of any offset other than the target register and the window returns zero. A write there changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_off | input | 16 | Register byte offset |
| acc_size | input | 4 | Access size in bytes (1 to 8) |
| acc_wdata | input | 64 | Write data, right-aligned |
| acc_rdata | output | 64 | Read data |
| acc_rvalid | output | 1 | Read data valid pulse |
| acc_err | output | 1 | Unsupported data-window size pulse |
| tgt_bus | output | 8 | Bus of the programmed target, for presence lookup |
| tgt_devfn | output | 8 | Device/function of the programmed target, for lookup |
| dev_present | input | 1 | A device answers at tgt_bus/tgt_devfn |
| dev_cfg_size | input | 13 | Configuration-space size of that device in bytes |
| cfg_req | output | 1 | Configuration request pulse |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Request bus number |
| cfg_devfn | output | 8 | Request device/function |
| cfg_offset | output | 12 | Request dword-aligned register offset |
| cfg_lane | output | 2 | Request starting byte lane |
| cfg_size | output | 3 | Request size in bytes (1, 2 or 4) |
| cfg_wdata | output | 32 | Request write data, little-endian |
| cfg_rdata | input | 32 | Device read data, little-endian |
| cfg_rvalid | input | 1 | Device read data valid |

## Verification
The bench aims at the limit boundary: offset 0x100 against a 256-byte device must be dropped, while 0xFFF against a 4096-byte device must go through. A design with an off-by-one compare would either forward the first or suppress the second. It also covers a register offset with its low bits set, which must be masked to a dword. A design that skipped the mask would send a wrong offset. Each swap size is checked in both directions, as are size-3 window accesses and a delayed device response. A wrong swap would corrupt lane order, a missing size check would leak a request, and an early completion would return stale data.

// File: rtl/cfgb_pkg.sv
// Package: shared types and constants for the configuration bridge.
// Assumes: sizes are byte counts; only 1, 2 and 4 are used by the swap logic.
package cfgb_pkg;
    typedef enum logic {ST_IDLE, ST_WAIT} cfgb_state_t;
    localparam logic [63:0] ALL_ONES = 64'hFFFF_FFFF_FFFF_FFFF;
endpackage

// File: rtl/cfgb_addr_decode.sv
// Module: splits the 64-bit target register into request fields and decides
// whether the addressed function can accept an access at the given lane.
// Assumes: presence and size inputs refer to the bus/devfn driven out here.
module cfgb_addr_decode #(
    parameter int CFG_SZ_W = 13
) (
    input  logic [63:0]         addr_q,
    input  logic [1:0]          lane,
    input  logic                dev_present,
    input  logic [CFG_SZ_W-1:0] dev_cfg_size,
    output logic [7:0]          bus,
    output logic [7:0]          devfn,
    output logic [11:0]         dw_off,
    output logic                target_ok
);
    localparam int EN_BIT = 63;
    logic [11:0] full_off;

    // Field extraction and limit check.
    always_comb begin
        bus       = addr_q[59:52];
        devfn     = addr_q[51:44];
        dw_off    = {addr_q[43:34], 2'b00};
        full_off  = {addr_q[43:34], lane};
        target_ok = addr_q[EN_BIT] && dev_present &&
                    ({{(CFG_SZ_W-12){1'b0}}, full_off} < dev_cfg_size);
    end
endmodule

// File: rtl/cfgb_lane_swap.sv
// Module: reorders bytes between big-endian register data and little-endian
// configuration data; size 1 keeps byte 0, 2 swaps the low pair, 4 reverses.
// Assumes: size is 1, 2 or 4; other codes give zero.
module cfgb_lane_swap #(
    parameter int NBYTES = 4
) (
    input  logic [NBYTES*8-1:0] din,
    input  logic [2:0]          size,
    output logic [NBYTES*8-1:0] dout
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        // Select the source byte for output byte i.
        always_comb begin
            dout[i*8 +: 8] = 8'h00;
            case (size)
                3'd1: if (i == 0) dout[i*8 +: 8] = din[7:0];
                3'd2: if (i < 2)  dout[i*8 +: 8] = din[(1-i)*8 +: 8];
                3'd4: if (i < 4)  dout[i*8 +: 8] = din[(3-i)*8 +: 8];
                default: dout[i*8 +: 8] = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/cfgb_ctrl.sv
// Module: access sequencer; classifies each register access, issues the
// registered configuration request, and returns read data or all ones.
// Assumes: one access per cycle at most; accesses during an outstanding
// read are ignored.
module cfgb_ctrl #(
    parameter int CFG_SZ_W = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_wr,
    input  logic                acc_rd,
    input  logic [3:0]          acc_size,
    input  logic [1:0]          lane,
    input  logic                win_hit,
    input  logic                win_size_ok,
    input  logic                full_ok,
    input  logic                addr_hit,
    input  logic [63:0]         addr_q,
    input  logic                target_ok,
    input  logic                dev_present,
    input  logic [CFG_SZ_W-1:0] dev_cfg_size,
    input  logic [7:0]          bus,
    input  logic [7:0]          devfn,
    input  logic [11:0]         dw_off,
    input  logic [31:0]         wr_swapped,
    input  logic [31:0]         rd_swapped,
    input  logic                cfg_rvalid,
    output logic                idle,
    output logic [63:0]         acc_rdata,
    output logic                acc_rvalid,
    output logic                acc_err,
    output logic                cfg_req,
    output logic                cfg_we,
    output logic [7:0]          cfg_bus,
    output logic [7:0]          cfg_devfn,
    output logic [11:0]         cfg_offset,
    output logic [1:0]          cfg_lane,
    output logic [2:0]          cfg_size,
    output logic [31:0]         cfg_wdata
);
    import cfgb_pkg::*;
    cfgb_state_t st;

    assign idle = (st == ST_IDLE);

    // Sequencer: classify access, launch request, complete reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            acc_rdata  <= '0;
            acc_rvalid <= 1'b0;
            acc_err    <= 1'b0;
            cfg_req    <= 1'b0;
            cfg_we     <= 1'b0;
            cfg_bus    <= '0;
            cfg_devfn  <= '0;
            cfg_offset <= '0;
            cfg_lane   <= '0;
            cfg_size   <= '0;
            cfg_wdata  <= '0;
        end else begin
            cfg_req    <= 1'b0;
            acc_rvalid <= 1'b0;
            acc_err    <= 1'b0;
            if (st == ST_IDLE) begin
                if (acc_wr) begin
                    if (win_hit) begin
                        if (!win_size_ok) begin
                            acc_err <= 1'b1;
                        end else if (target_ok) begin
                            cfg_req    <= 1'b1;
                            cfg_we     <= 1'b1;
                            cfg_bus    <= bus;
                            cfg_devfn  <= devfn;
                            cfg_offset <= dw_off;
                            cfg_lane   <= lane;
                            cfg_size   <= acc_size[2:0];
                            cfg_wdata  <= wr_swapped;
                        end
                    end
                end else if (acc_rd) begin
                    acc_rdata <= ALL_ONES;
                    if (win_hit) begin
                        if (!win_size_ok) begin
                            acc_err    <= 1'b1;
                            acc_rvalid <= 1'b1;
                        end else if (target_ok) begin
                            cfg_req    <= 1'b1;
                            cfg_we     <= 1'b0;
                            cfg_bus    <= bus;
                            cfg_devfn  <= devfn;
                            cfg_offset <= dw_off;
                            cfg_lane   <= lane;
                            cfg_size   <= acc_size[2:0];
                            st         <= ST_WAIT;
                        end else begin
                            acc_rvalid <= 1'b1;
                        end
                    end else begin
                        acc_rvalid <= 1'b1;
                        if (full_ok) acc_rdata <= addr_hit ? addr_q : 64'h0;
                    end
                end
            end else if (cfg_rvalid) begin
                acc_rvalid <= 1'b1;
                acc_rdata  <= {32'h0, rd_swapped};
                st         <= ST_IDLE;
            end
        end
    end

    // R4: a request only follows an access made while enabled.
    a_r4_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> $past(addr_q[63]));
    // R7: a request only follows an access with the device present.
    a_r7_req_needs_device: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> $past(dev_present));
    // R6: the requested offset lies inside the device's space.
    a_r6_req_in_limit: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> ({{(CFG_SZ_W-12){1'b0}}, cfg_offset[11:2], cfg_lane} < $past(dev_cfg_size)));
    // R10: an error pulse never comes with a request.
    a_r10_err_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> !cfg_req);
    // R11: device data in the wait state completes on the next cycle.
    a_r11_complete_next: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && cfg_rvalid) |=> acc_rvalid);
    // R8: a 2-byte write request carries the low pair swapped.
    a_r8_swap_two: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_we && cfg_size == 3'd2) |->
        (cfg_wdata[15:0] == {$past(wr_swapped[15:8]), $past(wr_swapped[7:0])}));
endmodule

// File: rtl/cfg_window_bridge.sv
// Module: top of the configuration address/data bridge. Holds the 64-bit
// target register, decodes the register offset and wires decode, swap and
// sequencer together.
// Assumes: the enumeration logic answers dev_present/dev_cfg_size
// combinationally for tgt_bus/tgt_devfn.
module cfg_window_bridge #(
    parameter int          OFF_W    = 16,
    parameter int          CFG_SZ_W = 13,
    parameter logic [15:0] AREG_OFF = 16'h0120,
    parameter logic [15:0] WIN_OFF  = 16'h0130
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_wr,
    input  logic                acc_rd,
    input  logic [OFF_W-1:0]    acc_off,
    input  logic [3:0]          acc_size,
    input  logic [63:0]         acc_wdata,
    output logic [63:0]         acc_rdata,
    output logic                acc_rvalid,
    output logic                acc_err,
    output logic [7:0]          tgt_bus,
    output logic [7:0]          tgt_devfn,
    input  logic                dev_present,
    input  logic [CFG_SZ_W-1:0] dev_cfg_size,
    output logic                cfg_req,
    output logic                cfg_we,
    output logic [7:0]          cfg_bus,
    output logic [7:0]          cfg_devfn,
    output logic [11:0]         cfg_offset,
    output logic [1:0]          cfg_lane,
    output logic [2:0]          cfg_size,
    output logic [31:0]         cfg_wdata,
    input  logic [31:0]         cfg_rdata,
    input  logic                cfg_rvalid
);
    localparam logic [OFF_W-1:0] WIN_A  = WIN_OFF[OFF_W-1:0];
    localparam logic [OFF_W-1:0] AREG_A = AREG_OFF[OFF_W-1:0];

    logic [63:0] addr_q;
    logic        win_hit, win_size_ok, full_ok, addr_hit, idle, target_ok;
    logic [11:0] dw_off;
    logic [31:0] wr_swapped, rd_swapped;

    // Offset classification.
    always_comb begin
        win_hit     = ({acc_off[OFF_W-1:2], 2'b00} == WIN_A);
        win_size_ok = (acc_size == 4'd1) || (acc_size == 4'd2) || (acc_size == 4'd4);
        full_ok     = (acc_size == 4'd8) && (acc_off[2:0] == 3'b000);
        addr_hit    = (acc_off == AREG_A);
    end

    // Target register: full-width aligned writes only, when not busy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (acc_wr && idle && !win_hit && full_ok && addr_hit)
            addr_q <= acc_wdata;
    end

    cfgb_addr_decode #(.CFG_SZ_W(CFG_SZ_W)) u_dec (
        .addr_q(addr_q), .lane(acc_off[1:0]), .dev_present(dev_present),
        .dev_cfg_size(dev_cfg_size), .bus(tgt_bus), .devfn(tgt_devfn),
        .dw_off(dw_off), .target_ok(target_ok)
    );

    cfgb_lane_swap #(.NBYTES(4)) u_wswap (
        .din(acc_wdata[31:0]), .size(acc_size[2:0]), .dout(wr_swapped)
    );

    cfgb_lane_swap #(.NBYTES(4)) u_rswap (
        .din(cfg_rdata), .size(cfg_size), .dout(rd_swapped)
    );

    cfgb_ctrl #(.CFG_SZ_W(CFG_SZ_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .acc_size(acc_size), .lane(acc_off[1:0]), .win_hit(win_hit),
        .win_size_ok(win_size_ok), .full_ok(full_ok), .addr_hit(addr_hit),
        .addr_q(addr_q), .target_ok(target_ok), .dev_present(dev_present),
        .dev_cfg_size(dev_cfg_size), .bus(tgt_bus), .devfn(tgt_devfn),
        .dw_off(dw_off), .wr_swapped(wr_swapped), .rd_swapped(rd_swapped),
        .cfg_rvalid(cfg_rvalid), .idle(idle), .acc_rdata(acc_rdata),
        .acc_rvalid(acc_rvalid), .acc_err(acc_err), .cfg_req(cfg_req),
        .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn),
        .cfg_offset(cfg_offset), .cfg_lane(cfg_lane), .cfg_size(cfg_size),
        .cfg_wdata(cfg_wdata)
    );

    // R2: the target register only changes after a write strobe.
    a_r2_areg_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_wr) |-> $stable(addr_q));
endmodule

// File: tb/sim_cfg_window_bridge.sv
module sim_cfg_window_bridge;
    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] AREG = 16'h0120;
    localparam logic [15:0] WIN  = 16'h0130;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic        en;
        logic [7:0]  bus;
        logic [7:0]  devfn;
        logic [11:0] rg;
        logic [1:0]  lane;
        logic [3:0]  size;
        logic [31:0] wd;
        logic        present;
        logic [12:0] csz;
        logic        exp_req;
        logic [31:0] exp_wd;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h12, 8'h34, 12'h040, 2'd0, 4'd4, 32'h11223344, 1'b1, 13'd256,  1'b1, 32'h44332211},
        '{1'b1, 8'hAB, 8'hCD, 12'h0FF, 2'd2, 4'd2, 32'h0000BEEF, 1'b1, 13'd256,  1'b1, 32'h0000EFBE},
        '{1'b1, 8'h01, 8'h08, 12'h010, 2'd3, 4'd1, 32'h000000A5, 1'b1, 13'd256,  1'b1, 32'h000000A5},
        '{1'b0, 8'h01, 8'h08, 12'h010, 2'd0, 4'd4, 32'h12345678, 1'b1, 13'd256,  1'b0, 32'h0},
        '{1'b1, 8'h00, 8'h00, 12'h100, 2'd0, 4'd4, 32'h12345678, 1'b1, 13'd256,  1'b0, 32'h0},
        '{1'b1, 8'h00, 8'h00, 12'h100, 2'd0, 4'd4, 32'hCAFEF00D, 1'b1, 13'd4096, 1'b1, 32'h0DF0FECA},
        '{1'b1, 8'h05, 8'h00, 12'hFFC, 2'd3, 4'd1, 32'h0000005A, 1'b1, 13'd4096, 1'b1, 32'h0000005A},
        '{1'b1, 8'h00, 8'h00, 12'h0FC, 2'd3, 4'd1, 32'h00000077, 1'b1, 13'd256,  1'b1, 32'h00000077},
        '{1'b1, 8'h02, 8'h10, 12'h020, 2'd0, 4'd4, 32'h12345678, 1'b0, 13'd256,  1'b0, 32'h0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_wr = 0, acc_rd = 0;
    logic [15:0] acc_off = '0;
    logic [3:0]  acc_size = '0;
    logic [63:0] acc_wdata = '0;
    logic [63:0] acc_rdata;
    logic acc_rvalid, acc_err;
    logic [7:0] tgt_bus, tgt_devfn;
    logic dev_present = 1'b1;
    logic [12:0] dev_cfg_size = 13'd256;
    logic cfg_req, cfg_we;
    logic [7:0] cfg_bus, cfg_devfn;
    logic [11:0] cfg_offset;
    logic [1:0] cfg_lane;
    logic [2:0] cfg_size;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata = '0;
    logic cfg_rvalid = 1'b0;

    int checks = 0, errors = 0, req_count = 0, err_count = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) begin
        if (cfg_req) req_count++;
        if (acc_err) err_count++;
    end

    cfg_window_bridge u0 (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .acc_off(acc_off), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid), .acc_err(acc_err),
        .tgt_bus(tgt_bus), .tgt_devfn(tgt_devfn), .dev_present(dev_present),
        .dev_cfg_size(dev_cfg_size), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn), .cfg_offset(cfg_offset),
        .cfg_lane(cfg_lane), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_addr(input logic en, input logic [7:0] b,
                                            input logic [7:0] df, input logic [11:0] rg);
        return {en, 3'b000, b, df, rg, 32'h0};
    endfunction

    // One write; returns with outputs of the following cycle visible.
    task automatic wr(input logic [15:0] off, input logic [3:0] sz, input logic [63:0] d);
        @(negedge clk);
        acc_wr = 1; acc_off = off; acc_size = sz; acc_wdata = d;
        @(negedge clk);
        acc_wr = 0;
    endtask

    // One read; serves a forwarded request after dly idle cycles.
    task automatic rd(input logic [15:0] off, input logic [3:0] sz,
                      input logic [31:0] dn, input int dly,
                      output logic [63:0] d, output logic v, output logic fwd);
        @(negedge clk);
        acc_rd = 1; acc_off = off; acc_size = sz;
        @(negedge clk);
        acc_rd = 0;
        fwd = cfg_req;
        if (fwd) begin
            for (int k = 0; k < dly; k++) begin
                check("R11 no early valid", {63'h0, acc_rvalid}, 64'h0);
                @(negedge clk);
            end
            check("R11 still waiting", {63'h0, acc_rvalid}, 64'h0);
            cfg_rdata = dn; cfg_rvalid = 1;
            @(negedge clk);
            cfg_rvalid = 0;
        end
        d = acc_rdata; v = acc_rvalid;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic v, f;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 no req", {63'h0, cfg_req}, 64'h0);
        check("R1 no rvalid", {63'h0, acc_rvalid}, 64'h0);
        rd(AREG, 4'd8, 32'h0, 0, d, v, f);
        check("R1 target reads zero", d, 64'h0);
        check("R2 read valid", {63'h0, v}, 64'h1);
        @(negedge clk);
        check("R2 valid single pulse", {63'h0, acc_rvalid}, 64'h0);

        // Vector table: window writes
        for (int i = 0; i < NV; i++) begin
            wr(AREG, 4'd8, mk_addr(VECS[i].en, VECS[i].bus, VECS[i].devfn, VECS[i].rg));
            dev_present = VECS[i].present; dev_cfg_size = VECS[i].csz;
            base = req_count;
            wr(WIN | {14'h0, VECS[i].lane}, VECS[i].size, {32'h0, VECS[i].wd});
            check($sformatf("R4/R6/R7 req vec %0d", i), {63'h0, cfg_req}, {63'h0, VECS[i].exp_req});
            if (VECS[i].exp_req) begin
                check($sformatf("R5 bus vec %0d", i), {56'h0, cfg_bus}, {56'h0, VECS[i].bus});
                check($sformatf("R5 devfn vec %0d", i), {56'h0, cfg_devfn}, {56'h0, VECS[i].devfn});
                check($sformatf("R5 offset vec %0d", i), {52'h0, cfg_offset}, {52'h0, VECS[i].rg & 12'hFFC});
                check($sformatf("R5 lane vec %0d", i), {62'h0, cfg_lane}, {62'h0, VECS[i].lane});
                check($sformatf("R8 wdata vec %0d", i), {32'h0, cfg_wdata}, {32'h0, VECS[i].exp_wd});
                check($sformatf("R5 we vec %0d", i), {63'h0, cfg_we}, 64'h1);
            end
            @(negedge clk);
            check($sformatf("R6 req count vec %0d", i), 64'(req_count - base), 64'(VECS[i].exp_req));
        end
        dev_present = 1; dev_cfg_size = 13'd256;

        // R2 readback
        wr(AREG, 4'd8, 64'h8123_4040_0000_0000);
        rd(AREG, 4'd8, 32'h0, 0, d, v, f);
        check("R2 readback", d, 64'h8123_4040_0000_0000);
        // R3 refused accesses
        wr(AREG + 16'd4, 4'd8, 64'h0);
        wr(AREG, 4'd4, 64'h0);
        rd(AREG, 4'd8, 32'h0, 0, d, v, f);
        check("R3 target unchanged", d, 64'h8123_4040_0000_0000);
        rd(AREG + 16'd4, 4'd8, 32'h0, 0, d, v, f);
        check("R3 misaligned read ones", d, ONES);
        rd(AREG, 4'd2, 32'h0, 0, d, v, f);
        check("R3 short read ones", d, ONES);
        // R12 other register
        wr(16'h0200, 4'd8, 64'h1234);
        rd(16'h0200, 4'd8, 32'h0, 0, d, v, f);
        check("R12 other reads zero", d, 64'h0);
        rd(AREG, 4'd8, 32'h0, 0, d, v, f);
        check("R12 write left target", d, 64'h8123_4040_0000_0000);

        // R9 read swaps
        rd(WIN, 4'd4, 32'hAABBCCDD, 0, d, v, f);
        check("R9 size4 forwarded", {63'h0, f}, 64'h1);
        check("R9 size4 data", d, 64'h0000_0000_DDCC_BBAA);
        rd(WIN | 16'd2, 4'd2, 32'h00001122, 1, d, v, f);
        check("R9 size2 data", d, 64'h0000_0000_0000_2211);
        check("R5 read lane", {62'h0, cfg_lane}, 64'd2);
        rd(WIN | 16'd1, 4'd1, 32'h000000E7, 0, d, v, f);
        check("R9 size1 data", d, 64'h0000_0000_0000_00E7);
        // R11 delayed completion
        rd(WIN, 4'd4, 32'h01020304, 3, d, v, f);
        check("R11 valid after data", {63'h0, v}, 64'h1);
        check("R11 data", d, 64'h0000_0000_0403_0201);
        @(negedge clk);
        check("R11 single pulse", {63'h0, acc_rvalid}, 64'h0);

        // R10 unsupported size
        base = req_count;
        wr(WIN, 4'd3, 64'h0);
        check("R10 err on write", {63'h0, acc_err}, 64'h1);
        check("R10 no req on write", {63'h0, cfg_req}, 64'h0);
        rd(WIN, 4'd3, 32'h0, 0, d, v, f);
        check("R10 read ones", d, ONES);
        check("R10 read valid", {63'h0, v}, 64'h1);
        check("R10 err on read", {63'h0, acc_err}, 64'h1);
        check("R10 no requests", 64'(req_count - base), 64'h0);

        // R4 / R6 / R7 reads dropped
        wr(AREG, 4'd8, mk_addr(1'b0, 8'h01, 8'h00, 12'h000));
        rd(WIN, 4'd4, 32'h0, 0, d, v, f);
        check("R4 disabled read ones", d, ONES);
        wr(AREG, 4'd8, mk_addr(1'b1, 8'h01, 8'h00, 12'h100));
        rd(WIN, 4'd4, 32'h0, 0, d, v, f);
        check("R6 limit read ones", d, ONES);
        wr(AREG, 4'd8, mk_addr(1'b1, 8'h01, 8'h00, 12'h010));
        dev_present = 0;
        check("R7 lookup bus", {56'h0, tgt_bus}, 64'h01);
        rd(WIN, 4'd4, 32'h0, 0, d, v, f);
        check("R7 absent read ones", d, ONES);
        check("R7 absent not forwarded", {63'h0, f}, 64'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule